// File: doc/BRIEF.md
# Script Register Byte Operation Unit

This unit carries out the byte-wide register instructions of a script-driven bus controller. It accepts one 32-bit command word with a single-cycle `start` strobe. Depending on the command, it reads one byte from an external 256-entry register file, combines that byte with an immediate byte or with the held first-byte-received byte (SFBR), and writes the result either back into the register file or into SFBR. A carry flag is kept inside the unit. The shift and addition operators use it, and two carry-control I/O commands can force it to 1 or 0.

A command word is a register instruction when bits [31:30] are `01` and the opcode in bits [29:27] is 5, 6 or 7. The operator sits in bits [26:24]. The register address is formed from bit 7 as its most significant bit and bits [22:16] as its lower seven bits. The immediate byte is bits [15:8]. Bit 23 selects SFBR as the second operand for read-modify-write. The register file read port has a fixed latency of `RD_LAT` cycles from `rf_rd_en` to valid `rf_rd_data`. The write strobe comes out registered, together with `done`.

Top module: `scsi_reg_alu`

## Requirements
- R1: After reset, `sfbr_o` and `carry_o` hold their reset values (0 by default), and `busy`, `done`, `rf_rd_en` and `rf_wr_en` are low.
- R2: Opcode 5 takes SFBR as the first operand and the immediate as the second. It writes the result to register address {cmd[7], cmd[22:16]} and does not read the register file.
- R3: Opcode 6 reads the addressed register as the first operand only when the operator is not 0, and uses the immediate as the second operand. It writes the result to SFBR and makes no register write.
- R4: Opcode 7 reads the addressed register when the operator is not 0. It takes SFBR as the second operand when cmd[23] is 1 and the immediate otherwise, and writes the result back to the same register.
- R5: Operators 0 (move second operand), 2 (OR), 3 (XOR) and 4 (AND) leave the carry unchanged.
- R6: Operator 1 shifts left, putting the carry into bit 0 and bit 7 into the carry. Operator 5 shifts right, putting the carry into bit 7 and bit 0 into the carry.
- R7: Operator 6 adds the two operands. Operator 7 adds them plus the carry. Both set the carry to the carry-out of the 8-bit sum.
- R8: With bits [31:30]=01, opcode 3 with cmd[10]=1 sets the carry and opcode 4 with cmd[10]=1 clears it. With cmd[10]=0 the carry is unchanged.
- R9: A command that needs no read raises `done` two cycles after `start` is sampled. A command that reads raises `rf_rd_en` for one cycle, starting the cycle after `start`, and raises `done` RD_LAT+2 cycles after `start`. `busy` is high from the cycle after `start` until `done`.
- R10: Commands outside bits [31:30]=01 with opcodes 3 to 7 complete with `done` and change neither SFBR, the carry nor the register file. A `start` while `busy` is ignored.
- R11: `done` is a single-cycle pulse per command, and `rf_wr_en` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled while idle |
| cmd | input | 32 | Command word |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| rf_rd_en | output | 1 | Register file read request |
| rf_rd_addr | output | 8 | Register file read address |
| rf_rd_data | input | 8 | Register file read data, RD_LAT cycles after request |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | 8 | Register file write address |
| rf_wr_data | output | 8 | Register file write data |
| sfbr_o | output | 8 | Current SFBR value |
| carry_o | output | 1 | Current carry flag |

## Verification
The properties assume that `start` is a level sampled only while the unit is idle. They also assume the register file returns the addressed byte exactly RD_LAT cycles after `rf_rd_en` and performs every write strobe it receives. The stimulus respects both. The bench drives `start` for one cycle at a time, except in the one case that deliberately holds it into the busy window. It models the register file with the same fixed latency and preloads the operand byte before each command.

// File: rtl/scsi_reg_alu_pkg.sv
package scsi_reg_alu_pkg;
   localparam int CMD_W  = 32;
   localparam int BYTE_W = 8;
   localparam int RA_W   = 8;

   typedef enum logic [2:0] {
      OPR_MOV = 3'd0, OPR_SHL = 3'd1, OPR_OR  = 3'd2, OPR_XOR = 3'd3,
      OPR_AND = 3'd4, OPR_SHR = 3'd5, OPR_ADD = 3'd6, OPR_ADC = 3'd7
   } opr_e;

   typedef enum logic [1:0] {
      RT_NONE = 2'd0, RT_FROM_SFBR = 2'd1, RT_TO_SFBR = 2'd2, RT_RMW = 2'd3
   } route_e;

   typedef struct packed {
      logic              is_rw;
      logic              c_set;
      logic              c_clr;
      route_e            route;
      opr_e              opr;
      logic              need_rd;
      logic              b_sfbr;
      logic [RA_W-1:0]   addr;
      logic [BYTE_W-1:0] imm;
   } dec_t;
endpackage

// File: rtl/scsi_reg_alu_dec.sv
module scsi_reg_alu_dec
   import scsi_reg_alu_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output dec_t             dec
);
   logic [1:0] cls;
   logic [2:0] opc;
   logic       io_cls;

   assign cls    = cmd[31:30];
   assign opc    = cmd[29:27];
   assign io_cls = (cls == 2'b01);

   always_comb begin
      dec         = '0;
      dec.opr     = opr_e'(cmd[26:24]);
      dec.addr    = {cmd[7], cmd[22:16]};
      dec.imm     = cmd[15:8];
      dec.b_sfbr  = cmd[23];
      dec.c_set   = io_cls && (opc == 3'd3) && cmd[10];
      dec.c_clr   = io_cls && (opc == 3'd4) && cmd[10];
      dec.is_rw   = io_cls && (opc >= 3'd5);
      if (dec.is_rw) begin
         unique case (opc)
            3'd5:    dec.route = RT_FROM_SFBR;
            3'd6:    dec.route = RT_TO_SFBR;
            default: dec.route = RT_RMW;
         endcase
      end
      dec.need_rd = dec.is_rw && (opc != 3'd5) && (cmd[26:24] != 3'd0);
   end
endmodule

// File: rtl/scsi_reg_alu_core.sv
module scsi_reg_alu_core
   import scsi_reg_alu_pkg::*;
(
   input  opr_e              opr,
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   input  logic              cin,
   output logic [BYTE_W-1:0] res,
   output logic              cout
);
   logic [BYTE_W:0] sum;

   always_comb begin
      sum  = '0;
      res  = b;
      cout = cin;
      unique case (opr)
         OPR_MOV: res = b;
         OPR_SHL: begin
            res  = {a[BYTE_W-2:0], cin};
            cout = a[BYTE_W-1];
         end
         OPR_OR:  res = a | b;
         OPR_XOR: res = a ^ b;
         OPR_AND: res = a & b;
         OPR_SHR: begin
            res  = {cin, a[BYTE_W-1:1]};
            cout = a[0];
         end
         OPR_ADD: begin
            sum  = {1'b0, a} + {1'b0, b};
            res  = sum[BYTE_W-1:0];
            cout = sum[BYTE_W];
         end
         OPR_ADC: begin
            sum  = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
            res  = sum[BYTE_W-1:0];
            cout = sum[BYTE_W];
         end
         default: res = b;
      endcase
   end
endmodule

// File: rtl/scsi_reg_alu.sv
module scsi_reg_alu
   import scsi_reg_alu_pkg::*;
#(
   parameter int                RD_LAT    = 1,
   parameter logic [BYTE_W-1:0] SFBR_RST  = '0,
   parameter logic              CARRY_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  cmd,
   output logic              busy,
   output logic              done,
   output logic              rf_rd_en,
   output logic [RA_W-1:0]   rf_rd_addr,
   input  logic [BYTE_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [RA_W-1:0]   rf_wr_addr,
   output logic [BYTE_W-1:0] rf_wr_data,
   output logic [BYTE_W-1:0] sfbr_o,
   output logic              carry_o
);
   localparam int CNT_W = (RD_LAT > 2) ? $clog2(RD_LAT) : 1;

   generate
      if (RD_LAT < 1 || RD_LAT > 16) begin : g_bad_lat
         $error("scsi_reg_alu: RD_LAT must lie in 1..16");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WAIT, ST_EXEC} state_e;

   state_e            state_q;
   dec_t              dec_in, dec_q;
   logic [BYTE_W-1:0] sfbr_q, op_a, op_b, alu_res;
   logic              carry_q, alu_c, wait_over;

   scsi_reg_alu_dec u_dec (.cmd(cmd), .dec(dec_in));

   generate
      if (RD_LAT <= 1) begin : g_lat_one
         assign wait_over = 1'b1;
      end else begin : g_lat_multi
         logic [CNT_W-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  wcnt_q <= '0;
            else if (state_q == ST_RD)   wcnt_q <= '0;
            else if (state_q == ST_WAIT) wcnt_q <= wcnt_q + 1'b1;
         end
         assign wait_over = (wcnt_q == CNT_W'(RD_LAT - 2));
      end
   endgenerate

   always_comb begin
      op_a = '0;
      if (dec_q.route == RT_FROM_SFBR) op_a = sfbr_q;
      else if (dec_q.need_rd)          op_a = rf_rd_data;
      op_b = (dec_q.route == RT_RMW && dec_q.b_sfbr) ? sfbr_q : dec_q.imm;
   end

   scsi_reg_alu_core u_core (
      .opr(dec_q.opr), .a(op_a), .b(op_b), .cin(carry_q),
      .res(alu_res), .cout(alu_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         dec_q      <= '0;
         sfbr_q     <= SFBR_RST;
         carry_q    <= CARRY_RST;
         done       <= 1'b0;
         rf_wr_en   <= 1'b0;
         rf_wr_addr <= '0;
         rf_wr_data <= '0;
      end else begin
         done     <= 1'b0;
         rf_wr_en <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               dec_q   <= dec_in;
               state_q <= dec_in.need_rd ? ST_RD : ST_EXEC;
            end
            ST_RD:   state_q <= (RD_LAT <= 1) ? ST_EXEC : ST_WAIT;
            ST_WAIT: if (wait_over) state_q <= ST_EXEC;
            ST_EXEC: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
               if (dec_q.is_rw) carry_q <= alu_c;
               else if (dec_q.c_set) carry_q <= 1'b1;
               else if (dec_q.c_clr) carry_q <= 1'b0;
               if (dec_q.route == RT_TO_SFBR) sfbr_q <= alu_res;
               if (dec_q.route == RT_FROM_SFBR || dec_q.route == RT_RMW) begin
                  rf_wr_en   <= 1'b1;
                  rf_wr_addr <= dec_q.addr;
                  rf_wr_data <= alu_res;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign rf_rd_en   = (state_q == ST_RD);
   assign rf_rd_addr = dec_q.addr;
   assign sfbr_o     = sfbr_q;
   assign carry_o    = carry_q;
endmodule

// File: rtl/scsi_reg_alu_chk.sv
module scsi_reg_alu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       rf_rd_en,
   input logic       rf_wr_en,
   input logic [7:0] sfbr_o,
   input logic       carry_o
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!done && !busy && !rf_wr_en));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R11
   wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_wr_en |-> done);
   // R8
   carry_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(carry_o) |-> done);
   // R3
   sfbr_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sfbr_o) |-> done);
   // R9
   rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_rd_en |-> busy);
   // R9
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
   // R9
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_rd_en |=> !rf_rd_en);
endmodule

bind scsi_reg_alu scsi_reg_alu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .sfbr_o(sfbr_o), .carry_o(carry_o)
);

// File: tb/scsi_reg_alu_tb.sv
module scsi_reg_alu_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] cmd = '0;
   logic        busy, done, rf_rd_en, rf_wr_en, carry_o;
   logic [7:0]  rf_rd_addr, rf_rd_data, rf_wr_addr, rf_wr_data, sfbr_o;
   logic [7:0]  mem [256];
   int checks = 0, fails = 0;
   int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, lat = 0;
   logic [7:0]  wr_a = '0, wr_d = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_reg_alu dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .busy(busy), .done(done),
      .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
      .sfbr_o(sfbr_o), .carry_o(carry_o)
   );

   always @(posedge clk) begin
      if (rf_rd_en) rf_rd_data <= mem[rf_rd_addr];
      if (rf_wr_en) mem[rf_wr_addr] <= rf_wr_data;
   end

   always @(negedge clk) begin
      if (rf_rd_en) rd_cnt++;
      if (done) done_cnt++;
      if (rf_wr_en) begin wr_cnt++; wr_a = rf_wr_addr; wr_d = rf_wr_data; end
   end

   function automatic logic [31:0] mk(input logic [2:0] opc, input logic [2:0] opr,
                                      input logic b23, input logic [7:0] ad, input logic [7:0] imm);
      return {2'b01, opc, opr, b23, ad[6:0], imm, ad[7], 7'b0};
   endfunction

   typedef struct packed {
      logic [31:0] cmd;
      logic [7:0]  sfbr_in;
      logic        c_in;
      logic [7:0]  reg_in;
      logic [7:0]  exp_v;
      logic        exp_c;
   } vec_t;

   localparam vec_t VECS [16] = '{
      '{mk(5,0,0,8'h85,8'h5A), 8'h12, 1'b1, 8'h00, 8'h5A, 1'b1},
      '{mk(5,2,0,8'h10,8'hA0), 8'h0F, 1'b0, 8'h00, 8'hAF, 1'b0},
      '{mk(5,6,0,8'h11,8'h20), 8'hF0, 1'b0, 8'h00, 8'h10, 1'b1},
      '{mk(6,3,0,8'h22,8'h0F), 8'h00, 1'b0, 8'hFF, 8'hF0, 1'b0},
      '{mk(6,4,0,8'hA3,8'h0F), 8'h55, 1'b1, 8'h3C, 8'h0C, 1'b1},
      '{mk(6,0,0,8'h24,8'h77), 8'h01, 1'b0, 8'h99, 8'h77, 1'b0},
      '{mk(7,1,0,8'h30,8'h00), 8'h00, 1'b1, 8'h81, 8'h03, 1'b1},
      '{mk(7,1,0,8'h31,8'h00), 8'h00, 1'b0, 8'h40, 8'h80, 1'b0},
      '{mk(7,5,0,8'hB2,8'h00), 8'h00, 1'b1, 8'h01, 8'h80, 1'b1},
      '{mk(7,5,0,8'h33,8'h00), 8'h00, 1'b0, 8'h02, 8'h01, 1'b0},
      '{mk(7,7,0,8'h34,8'h00), 8'h00, 1'b1, 8'hFF, 8'h00, 1'b1},
      '{mk(7,7,0,8'h35,8'h01), 8'h00, 1'b0, 8'h7F, 8'h80, 1'b0},
      '{mk(7,6,1,8'h36,8'hFF), 8'h30, 1'b0, 8'h10, 8'h40, 1'b0},
      '{mk(7,0,1,8'hC7,8'h11), 8'h99, 1'b1, 8'h00, 8'h99, 1'b1},
      '{mk(6,7,0,8'h38,8'h7F), 8'h00, 1'b1, 8'h80, 8'h00, 1'b1},
      '{mk(7,6,0,8'h39,8'h40), 8'h00, 1'b0, 8'hC0, 8'h00, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic issue(input logic [31:0] c);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; done_cnt = 0; lat = 0;
      cmd = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      #1;
      if (lat >= 20) chk(1'b0, "R9", "no done", lat, 0);
   endtask

   function automatic string opc_tag(input logic [2:0] o);
      if (o == 3'd5) return "R2";
      if (o == 3'd6) return "R3";
      return "R4";
   endfunction

   function automatic string opr_tag(input logic [2:0] o);
      if (o == 3'd1 || o == 3'd5) return "R6";
      if (o >= 3'd6) return "R7";
      return "R5";
   endfunction

   task automatic run_vec(input vec_t v);
      logic [2:0] opc = v.cmd[29:27];
      logic [2:0] opr = v.cmd[26:24];
      logic [7:0] ad  = {v.cmd[7], v.cmd[22:16]};
      int exp_rd = (opc != 3'd5 && opr != 3'd0) ? 1 : 0;
      issue(mk(6, 0, 0, 8'h00, v.sfbr_in));
      issue(v.c_in ? 32'h5800_0400 : 32'h6000_0400);
      mem[ad] = v.reg_in;
      issue(v.cmd);
      chk(rd_cnt == exp_rd, opc_tag(opc), "read count", rd_cnt, exp_rd);
      chk(lat == (exp_rd ? 3 : 2), "R9", "latency", lat, exp_rd ? 3 : 2);
      chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
      if (opc == 3'd6) begin
         chk(sfbr_o == v.exp_v, opc_tag(opc), "sfbr", sfbr_o, v.exp_v);
         chk(wr_cnt == 0, opc_tag(opc), "writes", wr_cnt, 0);
      end else begin
         chk(wr_cnt == 1, opc_tag(opc), "writes", wr_cnt, 1);
         chk(wr_a == ad, opc_tag(opc), "wr addr", wr_a, ad);
         chk(wr_d == v.exp_v, opr_tag(opr), "wr data", wr_d, v.exp_v);
         chk(sfbr_o == v.sfbr_in, opc_tag(opc), "sfbr kept", sfbr_o, v.sfbr_in);
      end
      chk(carry_o == v.exp_c, opr_tag(opr), "carry", carry_o, v.exp_c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sfbr_o == 8'h00 && carry_o == 1'b0, "R1", "reset regs", {sfbr_o, 7'b0, carry_o}, 0);
      chk(!busy && !done && !rf_rd_en && !rf_wr_en, "R1", "reset strobes",
          {busy, done, rf_rd_en, rf_wr_en}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < 16; i++) run_vec(VECS[i]);

      // R8 carry set/clear and bit 10 gating
      issue(32'h5800_0400);
      chk(carry_o == 1'b1, "R8", "set carry", carry_o, 1);
      issue(32'h6000_0000);
      chk(carry_o == 1'b1, "R8", "clear w/o bit10", carry_o, 1);
      issue(32'h6000_0400);
      chk(carry_o == 1'b0, "R8", "clear carry", carry_o, 0);
      issue(32'h5800_0000);
      chk(carry_o == 1'b0, "R8", "set w/o bit10", carry_o, 0);

      // R10 foreign commands: class 10 with rw fields, I/O opcode 1
      issue(mk(6, 0, 0, 8'h00, 8'h3C));
      issue(mk(6, 0, 0, 8'h00, 8'hE1) ^ 32'hC000_0000);
      chk(sfbr_o == 8'h3C && wr_cnt == 0 && rd_cnt == 0, "R10", "class 10 effect",
          {sfbr_o, 4'(wr_cnt), 4'(rd_cnt)}, 16'h3C00);
      chk(lat == 2 && done_cnt == 1, "R10", "class 10 done", lat, 2);
      issue(mk(1, 7, 1, 8'h40, 8'hFF));
      chk(sfbr_o == 8'h3C && wr_cnt == 0 && carry_o == 1'b0, "R10", "opcode 1 effect",
          {sfbr_o, 4'(wr_cnt), 3'b0, carry_o}, 16'h3C00);

      // R10 start while busy is ignored
      mem[8'h50] = 8'h05;
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
      cmd = mk(7, 6, 0, 8'h50, 8'h03); start = 1'b1;
      @(negedge clk);
      cmd = mk(6, 0, 0, 8'h00, 8'hEE);
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      chk(done_cnt == 1, "R10", "busy start done count", done_cnt, 1);
      chk(sfbr_o == 8'h3C, "R10", "busy start sfbr", sfbr_o, 8'h3C);
      chk(wr_cnt == 1 && wr_d == 8'h08, "R4", "rmw under busy", wr_d, 8'h08);

      report();
   end
endmodule